// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

The block collects up to 29 interrupt sources, numbered 1 to 29, and serves two interrupt lines: a normal one and a fast one. A source counts as pending while its level-sensitive hardware request is high or while software holds a request for it. Each source carries a 4-bit priority and a target bit that steers it to one of the two lines. Each line has its own priority threshold. Combinational logic picks the winning pending source for each line and raises that line whenever there is a winner.

Software works through a word-wide register bus. Reads are combinational and writes take effect on the clock edge. The vector register of a line returns a ready-made table pointer. The pointer is a software-written base aligned to 2048 bytes, with the winning source number placed in bits 7:3. This scales the index by the 8-byte size of a two-word table entry. A handler can use the value straight away as an address, or as a plain index when the base is zero.

Register words, at byte address = word * 4: source n config at word n (1..29), normal vector at 0x100, fast vector at 0x104, normal threshold at 0x180, fast threshold at 0x184, pending at 0x200.

Top module: `intc_vec_top`

## Requirements
- R1: The pending register (0x200) has bit n set, for n in 1..29, exactly when req_i[n] is high or the software request of source n is set. Bits 0, 30 and 31 always read 0.
- R2: A write to a source config word with bit 30 set loads bit 16 of the data into that source's software request; a write with bit 30 clear leaves the request unchanged. The config word reads priority in bits 3:0, target in bit 8 and the software request in bit 16.
- R3: A write to a config word with bit 31 set loads the priority from bits 3:0 and the target from bit 8 (0 = normal line, 1 = fast line). A source with priority 0 never wins.
- R4: A source qualifies for its line only when its priority is strictly greater than that line's threshold (bits 3:0 at 0x180 or 0x184). A threshold of 15 blocks every source on that line.
- R5: Among qualifying sources on a line, the highest priority wins. Ties go to the lowest source number.
- R6: Each line considers only the sources whose target selects it, and uses only its own threshold.
- R7: A vector read returns the stored base in bits 31:11 and the winning source number in bits 7:3. Bits 10:8 and 2:0 read 0. An index of 0 means no qualifying source. A write stores bits 31:11 and discards the rest.
- R8: nrm_irq_o and fast_irq_o are high exactly when the vector index of their line is non-zero, in the same cycle the inputs change.
- R9: After reset all priorities, targets, software requests, thresholds and bases are 0.
- R10: Hardware requests are not latched: once req_i[n] falls, with no software request, pending bit n and any win by source n disappear at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr_i | input | 10 | Byte address; bits 1:0 ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| req_i | input | 29 | Hardware requests, bit index n-1 for source n (packed as [29:1]) |
| nrm_irq_o | output | 1 | Normal interrupt line |
| fast_irq_o | output | 1 | Fast interrupt line |

## Verification
Two functions share a cycle in this block: a source's pending bit can come from the hardware level and from the software request at once, and the resolvers of both lines evaluate the same pending word in the same cycle. The bench provokes the first case by setting a software request while the matching request line is also high, then dropping one of the two. The source must stay pending until both are gone. It provokes the second by raising sources steered to both lines together and reading both vector registers against the table's expected indices. It also changes a target bit between reads and judges whether the win moves to the other line.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 10;
  localparam int unsigned IDX_LSB    = 3;   // index scaled by 8-byte entry
  localparam int unsigned BASE_LSB   = 11;  // 2048-byte aligned base
  localparam int unsigned NUM_TGT    = 2;
  localparam int unsigned TGT_NRM    = 0;
  localparam int unsigned TGT_FAST   = 1;
  // word addresses (byte address >> 2)
  localparam logic [ADDR_W-3:0] W_VEC0  = 8'h40;
  localparam logic [ADDR_W-3:0] W_VEC1  = 8'h41;
  localparam logic [ADDR_W-3:0] W_THR0  = 8'h60;
  localparam logic [ADDR_W-3:0] W_THR1  = 8'h61;
  localparam logic [ADDR_W-3:0] W_PEND  = 8'h80;
  // config word fields
  localparam int unsigned CFG_TGT_BIT = 8;
  localparam int unsigned CFG_SW_BIT  = 16;
  localparam int unsigned CFG_SWWE    = 30;
  localparam int unsigned CFG_PRWE    = 31;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-3:0]              waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_SRC:1]               req_i,
  output logic [NUM_SRC:1]               pend_o,
  output logic [NUM_SRC:1][PRIO_W-1:0]   prio_o,
  output logic [NUM_SRC:1]               tgt_o,
  output logic [NUM_SRC:1]               sw_o
);
  for (genvar n = 1; n <= NUM_SRC; n++) begin : g_src
    logic sel;
    assign sel = we_i && (waddr_i == (ADDR_W-2)'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[n] <= '0;
        tgt_o[n]  <= 1'b0;
        sw_o[n]   <= 1'b0;
      end else if (sel) begin
        if (wdata_i[CFG_PRWE]) begin
          prio_o[n] <= wdata_i[PRIO_W-1:0];
          tgt_o[n]  <= wdata_i[CFG_TGT_BIT];
        end
        if (wdata_i[CFG_SWWE]) sw_o[n] <= wdata_i[CFG_SW_BIT];
      end
    end

    // level request, not latched
    assign pend_o[n] = req_i[n] | sw_o[n];
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = 5,
  parameter bit          MY_TGT  = 1'b0
) (
  input  logic [NUM_SRC:1]             pend_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC:1]             tgt_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [IDX_W-1:0]             idx_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: ties keep the lowest number
  always_comb begin
    best  = thr_i;
    idx_o = '0;
    for (int unsigned n = 1; n <= NUM_SRC; n++) begin
      if (pend_i[n] && (tgt_i[n] == MY_TGT) && (prio_i[n] > best)) begin
        best  = prio_i[n];
        idx_o = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/intc_vec_top.sv
module intc_vec_top
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_SRC:1]  req_i,
  output logic              nrm_irq_o,
  output logic              fast_irq_o
);
  localparam int unsigned IDX_W  = BASE_LSB - IDX_LSB - 3;
  localparam int unsigned BASE_W = DATA_W - BASE_LSB;

  logic [ADDR_W-3:0]             waddr;
  logic [NUM_SRC:1]              pend;
  logic [NUM_SRC:1][PRIO_W-1:0]  prio;
  logic [NUM_SRC:1]              tgt;
  logic [NUM_SRC:1]              sw;
  logic [PRIO_W-1:0]             thr_q  [NUM_TGT];
  logic [BASE_W-1:0]             base_q [NUM_TGT];
  logic [IDX_W-1:0]              idx    [NUM_TGT];
  logic [DATA_W-1:0]             vec    [NUM_TGT];
  logic                          unused_bits;

  assign waddr       = bus_addr_i[ADDR_W-1:2];
  assign unused_bits = ^bus_addr_i[1:0];

  intc_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .waddr_i (waddr),
    .wdata_i (bus_wdata_i),
    .req_i   (req_i),
    .pend_o  (pend),
    .prio_o  (prio),
    .tgt_o   (tgt),
    .sw_o    (sw)
  );

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic thr_sel, vec_sel;
    assign thr_sel = bus_we_i && (waddr == W_THR0 + (ADDR_W-2)'(t));
    assign vec_sel = bus_we_i && (waddr == W_VEC0 + (ADDR_W-2)'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        thr_q[t]  <= '0;
        base_q[t] <= '0;
      end else begin
        if (thr_sel) thr_q[t]  <= bus_wdata_i[PRIO_W-1:0];
        if (vec_sel) base_q[t] <= bus_wdata_i[DATA_W-1:BASE_LSB];
      end
    end

    intc_prio_pick #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .MY_TGT(t == TGT_FAST)
    ) u_pick (
      .pend_i (pend),
      .prio_i (prio),
      .tgt_i  (tgt),
      .thr_i  (thr_q[t]),
      .idx_o  (idx[t])
    );

    assign vec[t] = {base_q[t], 3'b000, idx[t], 3'b000};
  end

  assign nrm_irq_o  = |idx[TGT_NRM];
  assign fast_irq_o = |idx[TGT_FAST];

  always_comb begin
    bus_rdata_o = '0;
    if (waddr == W_PEND) begin
      bus_rdata_o[NUM_SRC:1] = pend;
    end else if (waddr == W_VEC0) begin
      bus_rdata_o = vec[TGT_NRM];
    end else if (waddr == W_VEC1) begin
      bus_rdata_o = vec[TGT_FAST];
    end else if (waddr == W_THR0) begin
      bus_rdata_o[PRIO_W-1:0] = thr_q[TGT_NRM];
    end else if (waddr == W_THR1) begin
      bus_rdata_o[PRIO_W-1:0] = thr_q[TGT_FAST];
    end else begin
      for (int unsigned n = 1; n <= NUM_SRC; n++) begin
        if (waddr == (ADDR_W-2)'(n)) begin
          bus_rdata_o[PRIO_W-1:0]  = prio[n];
          bus_rdata_o[CFG_TGT_BIT] = tgt[n];
          bus_rdata_o[CFG_SW_BIT]  = sw[n];
        end
      end
    end
  end
endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 29
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [NUM_SRC:1]  req_i,
  input logic              nrm_irq_o,
  input logic              fast_irq_o
);
  logic [ADDR_W-3:0] w;
  assign w = bus_addr_i[ADDR_W-1:2];

  // R1
  pend_unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w == W_PEND) |-> (bus_rdata_o[0] == 1'b0 && bus_rdata_o[DATA_W-1:NUM_SRC+1] == '0));

  // R1
  pend_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w == W_PEND) |-> ((bus_rdata_o[NUM_SRC:1] & req_i) == req_i));

  // R7
  vec_gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w == W_VEC0 || w == W_VEC1) |-> (bus_rdata_o[10:8] == 3'b000 && bus_rdata_o[2:0] == 3'b000));

  // R8
  nrm_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w == W_VEC0) |-> (nrm_irq_o == (bus_rdata_o[7:3] != '0)));

  // R8
  fast_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w == W_VEC1) |-> (fast_irq_o == (bus_rdata_o[7:3] != '0)));
endmodule

bind intc_vec_top intc_vec_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .req_i       (req_i),
  .nrm_irq_o   (nrm_irq_o),
  .fast_irq_o  (fast_irq_o)
);

// File: tb/tb_intc_vec_top.sv
module tb_intc_vec_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [9:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [29:1] req_i = '0;
  logic        nrm_irq_o, fast_irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  intc_vec_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .req_i(req_i),
    .nrm_irq_o(nrm_irq_o), .fast_irq_o(fast_irq_o)
  );

  // stimulus table: request mask (bit n = source n), normal threshold, expected indices
  localparam logic [29:0] TV_REQ [NV] = '{
    30'h8, 30'h100008, 30'h1080, 30'h1008, 30'h8, 30'h88,
    30'h100000, 30'h10, 30'h101088, 30'h2000000, 30'h2001080};
  localparam logic [3:0] TV_THR [NV] = '{0, 0, 0, 0, 5, 5, 1, 0, 15, 0, 8};
  localparam logic [4:0] TV_NRM [NV] = '{3, 3, 7, 12, 0, 7, 20, 0, 0, 0, 7};
  localparam logic [4:0] TV_FST [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 25, 25};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  function automatic logic [31:0] cfg(input int p, input bit t);
    return 32'h8000_0000 | (t ? 32'h100 : 32'h0) | 32'(p);
  endfunction

  initial begin : wdog
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    rd(10'h200, d); chk("R9 pending", d, 0);
    rd(10'h100, d); chk("R9 nrm vector", d, 0);
    rd(10'h104, d); chk("R9 fast vector", d, 0);
    rd(10'h180, d); chk("R9 threshold", d, 0);
    rd(10'h00C, d); chk("R9 config src3", d, 0);
    chk("R9 lines", {nrm_irq_o, fast_irq_o}, 0);

    // configuration for the table
    wr(10'h00C, cfg(5, 0));   // src3
    wr(10'h010, cfg(0, 0));   // src4 disabled
    wr(10'h01C, cfg(9, 0));   // src7
    wr(10'h030, cfg(9, 0));   // src12
    wr(10'h050, cfg(2, 0));   // src20
    wr(10'h064, cfg(14, 1));  // src25 fast
    rd(10'h064, d); chk("R3 config readback", d, 32'h10E);

    for (int i = 0; i < NV; i++) begin
      wr(10'h180, 32'(TV_THR[i]));
      req_i = TV_REQ[i][29:1];
      rd(10'h100, d); chk($sformatf("R5 R4 R3 vec%0d nrm", i), d, {24'b0, TV_NRM[i], 3'b0});
      chk($sformatf("R8 vec%0d nrm line", i), 32'(nrm_irq_o), 32'(TV_NRM[i] != 0));
      rd(10'h104, d); chk($sformatf("R6 vec%0d fast", i), d, {24'b0, TV_FST[i], 3'b0});
      chk($sformatf("R8 vec%0d fast line", i), 32'(fast_irq_o), 32'(TV_FST[i] != 0));
    end

    // R1 all requests high, unused bits stay zero
    req_i = '1;
    rd(10'h200, d); chk("R1 pending all", d, 32'h3FFF_FFFE);

    // R10 level requests, not latched
    wr(10'h180, 0);
    req_i = '0; req_i[7] = 1'b1;
    rd(10'h100, d); chk("R10 src7 wins", d, 32'h38);
    req_i[7] = 1'b0;
    rd(10'h100, d); chk("R10 src7 gone", d, 0);
    rd(10'h200, d); chk("R10 pending clear", d, 0);

    // R2 software request, overlapping the hardware level
    wr(10'h014, cfg(6, 0) | 32'h4001_0000);  // src5 prio 6, sw on
    rd(10'h014, d); chk("R2 config sw bit", d, 32'h1_0006);
    rd(10'h200, d); chk("R2 pending sw", d, 32'h20);
    rd(10'h100, d); chk("R2 src5 wins", d, 32'h28);
    req_i[5] = 1'b1;
    wr(10'h014, 32'h4000_0000);              // sw off, hw high
    rd(10'h200, d); chk("R2 hw keeps pending", d, 32'h20);
    req_i[5] = 1'b0;
    rd(10'h200, d); chk("R2 sw cleared", d, 0);
    wr(10'h014, 32'h0001_0000);              // no enable: ignored
    rd(10'h014, d); chk("R2 write without enable", d, 32'h6);

    // R7 base and discarded low bits
    req_i[12] = 1'b1;
    wr(10'h100, 32'hABCD_E8FF);
    rd(10'h100, d); chk("R7 nrm base", d, 32'hABCD_E860);
    wr(10'h104, 32'hFFFF_FFFF);
    rd(10'h104, d); chk("R7 fast base empty", d, 32'hFFFF_F800);

    // R6 retarget src12 to fast; fast threshold separate
    wr(10'h030, cfg(9, 1));
    rd(10'h104, d); chk("R6 fast gets src12", d, 32'hFFFF_F860);
    rd(10'h100, d); chk("R6 nrm loses src12", d, 32'hABCD_E800);
    wr(10'h184, 15);
    rd(10'h104, d); chk("R4 fast thr 15 blocks", d, 32'hFFFF_F800);
    chk("R8 fast line low", 32'(fast_irq_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule